// File: doc/BRIEF.md
# Two-Wire Byte-Memory Slave Front End

This block is the slave side of a two-wire serial bus for a small byte-wide memory organised as two 256-byte pages. It samples the clock and data lines with the system clock through synchronizers and detects START and STOP conditions. After each START it decodes a device byte that carries a fixed type code, two select bits compared against strap inputs, a page bit and a direction bit. The local memory array sits outside this block. It is reached through a plain address / write-strobe / read-strobe byte port, and its read data is expected to be combinational from the address.

A write sequence sends the device byte, then one word-address byte, then any number of data bytes. The slave acknowledges every byte. Each data byte goes into the array at the current pointer, and the pointer then advances. A read sequence returns bytes starting at the current pointer, MSB first, for as long as the master acknowledges. A master NACK ends the read, and the slave stays off the bus until the next START or STOP. A STOP that closes a write in which data was stored raises a single-cycle commit request, which starts the downstream programming cycle.

Top module: `i2cm_slave`

## Requirements
- R1: While reset is asserted and right after it, the data output enable, the commit request and the write strobe are all low, and the memory address is 0.
- R2: A falling data line while the clock is high is a START. A rising data line while the clock is high is a STOP. The slave changes its data output enable only while the clock line is low, unless it is releasing the line on a START or STOP.
- R3: The device byte is sent MSB first. Bits 7..4 must equal 1010 and bits 3..2 must equal the two select inputs (bit 3 against select bit 1). When both match, the slave pulls the data line low during the ninth clock. Bit 1 is the page bit and bit 0 is the direction bit (1 read, 0 write).
- R4: If the device byte does not match, the slave leaves the data line released. It acknowledges nothing further until the next START.
- R5: In a write, the slave acknowledges the byte after the device byte and loads it into the low 8 pointer bits. It acknowledges each later byte and writes it to the array at {page bit, pointer} with a one-cycle write strobe.
- R6: In a read, the slave sends the byte at the current pointer MSB first and then releases the line for the master's response. On ACK it sends the next byte. On NACK it drives nothing more, so further clocks read all ones.
- R7: A STOP that ends a write in which at least one data byte was stored gives exactly one single-cycle commit pulse. A write with no data bytes, or one ended by a repeated START, gives no pulse.
- R8: After every stored or fetched byte, the low 8 pointer bits increment and wrap from 0xFF to 0x00 inside the same page. The page bit is taken from each accepted device byte, and a read starts at the pointer left by the previous access.
- R9: A START that arrives in the middle of a byte discards the partial byte and returns the slave to device-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| dev_sel_i | input | 2 | Strap value the device-select bits must match |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |
| mem_addr_o | output | PAGE_AW+1 | Array address {page, pointer} |
| mem_wr_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rd_o | output | 1 | One-cycle strobe when a read byte is fetched |
| mem_rdata_i | input | 8 | Array data at mem_addr_o |
| commit_o | output | 1 | One-cycle request to start the programming cycle |

## Verification
Every one of the 128 seven-bit device addresses is tried with a write direction and one strap setting. A second byte follows each, which separates the two matching codes (the only ones that acknowledge) from the mismatches, where the slave must stay silent. Writes and reads that cross the 0xFF boundary in page 1 show the wrap inside the page and that page 0 stays separate. Reads ended by NACK and then clocked again show that the line is released. A START in the middle of a byte, a write closed by a repeated START, and a write holding only an address tell apart the cases where a commit pulse is due from those where it is not.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } st_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
  localparam int         BYTE_W    = 8;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg <= {stg[STAGES-2:0], d};
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cm_bus_events.sv
module i2cm_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cm_addr_ptr.sv
module i2cm_addr_ptr #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_page,
  input  logic            page_in,
  input  logic            set_low,
  input  logic [LO_W-1:0] low_in,
  input  logic            incr,
  output logic [LO_W:0]   addr
);
  logic            page_q, page_n;
  logic [LO_W-1:0] low_q, low_n;

  always_comb begin
    page_n = page_q;
    low_n  = low_q;
    if (set_page) page_n = page_in;
    if (set_low) begin
      low_n = low_in;
    end else if (incr) begin
      low_n = low_q + {{(LO_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 1'b0;
      low_q  <= '0;
    end else begin
      page_q <= page_n;
      low_q  <= low_n;
    end
  end

  assign addr = {page_q, low_q};
endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
  import i2cm_pkg::*;
#(
  parameter int PAGE_AW     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [1:0]           dev_sel_i,
  output logic                 sda_oe_o,
  output logic [PAGE_AW:0]     mem_addr_o,
  output logic                 mem_wr_o,
  output logic [BYTE_W-1:0]    mem_wdata_o,
  output logic                 mem_rd_o,
  input  logic [BYTE_W-1:0]    mem_rdata_i,
  output logic                 commit_o
);
  localparam int AW    = PAGE_AW + 1;
  localparam int CNT_W = $clog2(BYTE_W);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2cm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     ({scl_s, sda_s})
  );

  i2cm_bus_events u_ev (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  // state registers
  st_e               st_q, st_n, ret_q, ret_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              full_q, full_n;
  logic [BYTE_W-1:0] sh_q, sh_n, tx_q, tx_n;
  logic              oe_q, oe_n;
  logic              pend_q, pend_n;
  logic              commit_q, commit_n;

  // pointer controls
  logic set_page, set_low, incr;
  logic wr_c, rd_c, dev_hit, do_load;

  i2cm_addr_ptr #(.LO_W(PAGE_AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_page (set_page),
    .page_in  (sh_q[1]),
    .set_low  (set_low),
    .low_in   (PAGE_AW'(sh_q)),
    .incr     (incr),
    .addr     (mem_addr_o)
  );

  assign dev_hit = (sh_q[7:4] == TYPE_CODE) && (sh_q[3:2] == dev_sel_i);

  always_comb begin
    st_n     = st_q;
    ret_n    = ret_q;
    cnt_n    = cnt_q;
    full_n   = full_q;
    sh_n     = sh_q;
    tx_n     = tx_q;
    oe_n     = oe_q;
    pend_n   = pend_q;
    commit_n = 1'b0;
    set_page = 1'b0;
    set_low  = 1'b0;
    incr     = 1'b0;
    wr_c     = 1'b0;
    do_load  = 1'b0;

    if (stop_ev) begin
      commit_n = pend_q;
      pend_n   = 1'b0;
      st_n     = ST_IDLE;
      oe_n     = 1'b0;
      full_n   = 1'b0;
    end else if (start_ev) begin
      pend_n = 1'b0;
      st_n   = ST_DEV;
      oe_n   = 1'b0;
      full_n = 1'b0;
      cnt_n  = '0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(BYTE_W-1)) full_n = 1'b1;
          end else if (scl_fall && full_q) begin
            full_n = 1'b0;
            if (st_q == ST_DEV) begin
              if (dev_hit) begin
                oe_n     = 1'b1;
                st_n     = ST_ACK;
                set_page = 1'b1;
                ret_n    = sh_q[0] ? ST_RDATA : ST_WADDR;
              end else begin
                st_n = ST_SKIP;
              end
            end else if (st_q == ST_WADDR) begin
              oe_n    = 1'b1;
              st_n    = ST_ACK;
              set_low = 1'b1;
              ret_n   = ST_WDATA;
            end else begin
              oe_n   = 1'b1;
              st_n   = ST_ACK;
              wr_c   = 1'b1;
              incr   = 1'b1;
              pend_n = 1'b1;
              ret_n  = ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (ret_q == ST_RDATA) begin
              do_load = 1'b1;
            end else begin
              oe_n = 1'b0;
              st_n = ret_q;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(BYTE_W-1)) full_n = 1'b1;
          end else if (scl_fall) begin
            if (full_q) begin
              full_n = 1'b0;
              oe_n   = 1'b0;
              st_n   = ST_RACK;
            end else begin
              tx_n = {tx_q[BYTE_W-2:0], 1'b0};
              oe_n = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_s) begin
            st_n = ST_SKIP;
          end else if (scl_fall) begin
            cnt_n   = '0;
            do_load = 1'b1;
          end
        end
        default: begin
        end
      endcase

      if (do_load) begin
        incr = 1'b1;
        tx_n = mem_rdata_i;
        oe_n = ~mem_rdata_i[BYTE_W-1];
        st_n = ST_RDATA;
      end
    end
  end

  assign rd_c = do_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ret_q    <= ST_IDLE;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      sh_q     <= '0;
      tx_q     <= '0;
      oe_q     <= 1'b0;
      pend_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      ret_q    <= ret_n;
      cnt_q    <= cnt_n;
      full_q   <= full_n;
      sh_q     <= sh_n;
      tx_q     <= tx_n;
      oe_q     <= oe_n;
      pend_q   <= pend_n;
      commit_q <= commit_n;
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_wr_o    = wr_c;
  assign mem_rd_o    = rd_c;
  assign mem_wdata_o = sh_q;
  assign commit_o    = commit_q;

  localparam int UNUSED_AW = AW;
endmodule

// File: rtl/i2cm_slave_chk.sv
module i2cm_slave_chk
  import i2cm_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic commit,
  input logic mem_wr,
  input logic mem_rd,
  input logic page_bit,
  input st_e  st
);
  // R7: commit is a single-cycle pulse caused by a STOP
  a_r7_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_ev));

  // R2: the data driver moves only while the clock is low, or on START/STOP release
  a_r2_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev)));

  // R4: silent while skipping or idle
  a_r4_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP || st == ST_IDLE) |-> !sda_oe);

  // R5: write strobe lasts one cycle and never coincides with a read fetch
  a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  a_r6_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  // R8: a data write never changes the page
  a_r8_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (page_bit == $past(page_bit)));
endmodule

bind i2cm_slave i2cm_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .sda_oe   (sda_oe_o),
  .commit   (commit_o),
  .mem_wr   (mem_wr_o),
  .mem_rd   (mem_rd_o),
  .page_bit (mem_addr_o[PAGE_AW]),
  .st       (st_q)
);

// File: tb/i2cm_slave_test.sv
`timescale 1ns/1ps
module i2cm_slave_test;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic [1:0] dev_sel;
  logic       sda_oe, mem_wr, mem_rd, commit;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [512];
  wire        sda_bus = sda_m & ~sda_oe;

  int tests = 0;
  int fails = 0;
  int n_commit;
  int viol;
  logic prev_oe;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  i2cm_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .dev_sel_i  (dev_sel),
    .sda_oe_o   (sda_oe),
    .mem_addr_o (mem_addr),
    .mem_wr_o   (mem_wr),
    .mem_wdata_o(mem_wdata),
    .mem_rd_o   (mem_rd),
    .mem_rdata_i(mem_rdata),
    .commit_o   (commit)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 512; a++) mem[a] <= pat(a);
      n_commit <= 0;
      viol     <= 0;
      prev_oe  <= 1'b0;
    end else begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (commit) n_commit <= n_commit + 1;
      prev_oe <= sda_oe;
      if (sda_oe != prev_oe && scl_m) viol <= viol + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_bus;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq();
      d[i] = sda_bus;
      wq(); scl_m = 1'b0;
    end
    wq(); sda_m = nack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic       ack, ack2, hit;
    logic [7:0] d;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; dev_sel = 2'b10;
    repeat (6) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 0);
    chk("R1 commit in reset", commit, 0);
    chk("R1 wr in reset", mem_wr, 0);
    chk("R1 addr in reset", mem_addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", sda_oe, 0);

    // R3 / R4: sweep of every 7-bit address, write direction
    for (int a = 0; a < 128; a++) begin
      hit = (a[6:3] == 4'b1010) && (a[2:1] == dev_sel);
      start_c();
      send_byte({a[6:0], 1'b0}, ack);
      send_byte(8'h00, ack2);
      stop_c();
      chk($sformatf("R3 device ack a=%0h", a), ack, hit);
      chk($sformatf("R4 follow-up ack a=%0h", a), ack2, hit);
    end
    repeat (8) @(negedge clk);
    chk("R7 no commit for address-only writes", n_commit, 0);

    // R5 / R8: write across page-1 wrap
    dev_sel = 2'b01;
    start_c();
    send_byte(8'hA6, ack); chk("R3 write device ack", ack, 1);
    send_byte(8'hFE, ack); chk("R5 word address ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'hC0 + 8'(k), ack);
      chk("R5 data ack", ack, 1);
    end
    stop_c();
    repeat (8) @(negedge clk);
    chk("R7 one commit after write", n_commit, 1);
    chk("R5 byte @1FE", mem[9'h1FE], 8'hC0);
    chk("R5 byte @1FF", mem[9'h1FF], 8'hC1);
    chk("R8 wrap byte @100", mem[9'h100], 8'hC2);
    chk("R8 wrap byte @101", mem[9'h101], 8'hC3);
    chk("R8 page0 untouched @0FE", mem[9'h0FE], pat(9'h0FE));
    chk("R8 page0 untouched @000", mem[9'h000], pat(0));

    // R6: random read with wrap, ACK x3 then NACK
    start_c();
    send_byte(8'hA6, ack);
    send_byte(8'hFE, ack);
    start_c();
    send_byte(8'hA7, ack); chk("R3 read device ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k == 3, d);
      chk($sformatf("R6 read byte %0d", k), d, 8'hC0 + 8'(k));
    end
    recv_byte(1'b1, d);
    chk("R6 line released after NACK", d, 8'hFF);
    stop_c();
    repeat (8) @(negedge clk);
    chk("R7 no commit on address-only write", n_commit, 1);

    // R8: current-address read continues
    start_c();
    send_byte(8'hA7, ack);
    recv_byte(1'b1, d);
    stop_c();
    chk("R8 current address read @102", d, pat(9'h102));

    // R8: page 0 read at same low address
    start_c();
    send_byte(8'hA4, ack);
    send_byte(8'hFE, ack);
    start_c();
    send_byte(8'hA5, ack);
    recv_byte(1'b1, d);
    stop_c();
    chk("R8 page0 read @0FE", d, pat(9'h0FE));

    // R9: START mid-byte
    start_c();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    start_c();
    send_byte(8'hA6, ack); chk("R9 device ack after mid-byte START", ack, 1);
    send_byte(8'h10, ack);
    send_byte(8'h77, ack); chk("R9 data ack", ack, 1);
    stop_c();
    repeat (8) @(negedge clk);
    chk("R9 byte @110", mem[9'h110], 8'h77);
    chk("R7 commit after second write", n_commit, 2);

    // R7: write closed by repeated START gives no commit
    start_c();
    send_byte(8'hA6, ack);
    send_byte(8'h20, ack);
    send_byte(8'h55, ack);
    start_c();
    send_byte(8'hA7, ack);
    recv_byte(1'b1, d);
    stop_c();
    repeat (8) @(negedge clk);
    chk("R7 no commit after restart", n_commit, 2);
    chk("R5 byte @120", mem[9'h120], 8'h55);
    chk("R8 read after write @121", d, pat(9'h121));

    chk("R2 oe changes while SCL high", viol, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule